// File: doc/BRIEF.md
# Next-Fetch-Address Predictor

This block sits beside the instruction cache of a four-lane fetch front end and, in the same cycle as the fetch, proposes the address of the next fetch group. It holds two structures that are read together: a table of one-bit direction flags and a direct-mapped, tagged store of branch targets. When the target store holds an entry whose tag matches the fetch address and the direction flag for that address says "taken", the stored target becomes the next fetch address. In every other case the front end simply advances by one full fetch group of sixteen bytes.

Execute reports each resolved control transfer on a single update port. A taken transfer (taken branch, register jump or call) installs its target in the target store and sets its direction flag; a not-taken branch can only clear its direction flag and never allocates a target entry. A direction flag is rewritten only when the resolved outcome disagrees with it. Updates take effect at the clock edge, so a lookup in the same cycle still sees the old contents.

Top module: `nfa_predictor`

## Requirements
- R1: After a synchronous active-low reset every target entry is invalid and every direction flag is 0, so every lookup gives pred_taken=0 and next_pc=fetch_pc+16 until a taken update arrives.
- R2: When the target store misses, pred_taken is 0 and next_pc is fetch_pc+16, wrapping modulo 2^PC_W (0xFFFFFFF8 gives 0x00000008 for 32 bits).
- R3: The target store is indexed by fetch_pc bits [TB_IDX_W+1:2]; the tag is fetch_pc bits [PC_W-1:TB_IDX_W+2]; a hit needs a valid entry with an equal tag, so two addresses sharing an index but differing in tag do not hit each other.
- R4: When the target store hits and the direction flag is 1, pred_taken is 1 and next_pc is the stored target.
- R5: When the target store hits but the direction flag is 0, pred_taken is 0 and next_pc is fetch_pc+16.
- R6: The direction table is indexed by PC bits [DIR_IDX_W+1:2]; a flag of 1 means taken, 0 not taken; an update rewrites the flag at upd_pc to upd_taken only when the stored flag differs.
- R7: An update with upd_taken=1 writes valid, the tag of upd_pc and upd_target into the target entry selected by upd_pc, replacing whatever was there.
- R8: An update with upd_taken=0 leaves every target entry unchanged, whatever upd_target carries.
- R9: An update changes lookups from the next cycle on; a lookup in the cycle of the update sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address of the current fetch group |
| pred_taken | output | 1 | Prediction that the fetch group redirects |
| next_pc | output | PC_W | Proposed next fetch address |
| upd_valid | input | 1 | A resolved control transfer is reported this cycle |
| upd_pc | input | PC_W | Address of the resolved transfer |
| upd_taken | input | 1 | Resolved outcome, 1 for taken |
| upd_target | input | PC_W | Resolved target address |

## Verification
The bench builds the block with a 4-entry direction table and an 8-entry target store, so the direction table is smaller than the target store. That choice lets one address pair share a direction flag while sitting in different target entries, which makes it possible to observe that a not-taken update leaves a target entry intact, and a pair at 32-byte distance share a target index with different tags, exercising tag rejection. Random traffic over two address regions then mixes hits, tag conflicts, flag flips and fall-through wrap-around against a behavioural model.

// File: rtl/nfa_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the next-fetch-address predictor.
// Assumes fixed-size instructions and a fetch group of several lanes.
package nfa_pkg;
    localparam int unsigned INSN_BYTES  = 4;
    localparam int unsigned FETCH_LANES = 4;
    localparam int unsigned GROUP_BYTES = INSN_BYTES * FETCH_LANES;
    localparam int unsigned OFS_W       = $clog2(INSN_BYTES);

    // Outcome of combining the target store and the direction flag.
    typedef enum logic [1:0] {
        LK_MISS   = 2'd0,
        LK_HIT_NT = 2'd1,
        LK_HIT_T  = 2'd2
    } lookup_e;
endpackage

// File: rtl/nfa_dir_table.sv
`timescale 1ns/1ps
// One-bit direction table. Read combinationally at rd_idx; a flag is
// rewritten with the resolved outcome only when it disagrees with it.
// Assumes a single update per cycle.
module nfa_dir_table #(
    parameter int unsigned IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] flags_q;
    logic               mispredict;

    // Read port used by the lookup in the fetch cycle.
    assign rd_taken   = flags_q[rd_idx];
    // Update is needed only when the stored flag was wrong.
    assign mispredict = wr_en && (flags_q[wr_idx] != wr_taken);

    // Flag storage with reset to not-taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (mispredict) begin
            flags_q[wr_idx] <= wr_taken;
        end
    end

    AST_FLAG_ONLY_ON_WRONG: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (flags_q[wr_idx] != wr_taken)) |=> $stable(flags_q)); // R6
    AST_FLAG_TAKES_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> flags_q[$past(wr_idx)] == $past(wr_taken)); // R6
endmodule

// File: rtl/nfa_target_buffer.sv
`timescale 1ns/1ps
// Direct-mapped tagged store of taken-transfer targets. Lookup is
// combinational; only taken outcomes allocate or overwrite an entry.
// Assumes one update per cycle and that tags exclude the index bits.
module nfa_target_buffer #(
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned TAG_W  = 26,
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_hit,
    output logic [ADDR_W-1:0] rd_target,
    input  logic              wr_en,
    input  logic              wr_taken,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [ADDR_W-1:0] wr_target
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_q [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q [ENTRIES];
    logic [ENTRIES-1:0] tag_eq;
    logic               alloc;

    // Per-entry tag comparators; the read index picks one result.
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign tag_eq[e] = valid_q[e] && (tag_q[e] == rd_tag);
    end

    // Lookup result for the fetch cycle.
    assign rd_hit    = tag_eq[rd_idx];
    assign rd_target = tgt_q[rd_idx];
    // Only taken transfers are installed.
    assign alloc     = wr_en && wr_taken;

    // Valid bits, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (alloc) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and target payload; no reset needed behind the valid bits.
    always_ff @(posedge clk) begin
        if (alloc) begin
            tag_q[wr_idx] <= wr_tag;
            tgt_q[wr_idx] <= wr_target;
        end
    end

    AST_NO_ALLOC_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken) |=> $stable(valid_q)); // R8
    AST_KEEP_TARGET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && valid_q[wr_idx]) |=> tgt_q[$past(wr_idx)] == $past(tgt_q[wr_idx])); // R8
    AST_ALLOC_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)); // R7
endmodule

// File: rtl/nfa_next_select.sv
`timescale 1ns/1ps
// Chooses between the stored target and the sequential fetch-group
// address. Pure combinational; assumes the hit and flag are for fetch_pc.
module nfa_next_select #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              tb_hit,
    input  logic              dir_taken,
    input  logic [ADDR_W-1:0] fetch_pc,
    input  logic [ADDR_W-1:0] tb_target,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] next_pc
);
    import nfa_pkg::*;

    lookup_e           outcome;
    logic [ADDR_W-1:0] seq_pc;

    // Sequential successor: one whole fetch group ahead, wrapping.
    assign seq_pc = fetch_pc + ADDR_W'(GROUP_BYTES);

    // Classify the lookup.
    always_comb begin
        if (!tb_hit)        outcome = LK_MISS;
        else if (dir_taken) outcome = LK_HIT_T;
        else                outcome = LK_HIT_NT;
    end

    // Drive the prediction from the classification.
    always_comb begin
        pred_taken = (outcome == LK_HIT_T);
        next_pc    = pred_taken ? tb_target : seq_pc;
    end
endmodule

// File: rtl/nfa_predictor.sv
`timescale 1ns/1ps
// Next-fetch-address predictor for a four-lane fetch front end.
// Looks up a one-bit direction table and a tagged target store in the
// fetch cycle; execute updates both through one port. Assumes aligned
// instructions, so the low address bits below the instruction size are
// ignored by indexing and tagging.
module nfa_predictor #(
    parameter int unsigned PC_W      = 32,
    parameter int unsigned DIR_IDX_W = 6,
    parameter int unsigned TB_IDX_W  = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    output logic            pred_taken,
    output logic [PC_W-1:0] next_pc,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    import nfa_pkg::*;

    localparam int unsigned TAG_LSB = TB_IDX_W + OFS_W;
    localparam int unsigned TAG_W   = PC_W - TAG_LSB;

    logic                 dir_rd_taken;
    logic                 tb_hit;
    logic [PC_W-1:0]      tb_target;

    // Address field extraction for lookup and update.
    logic [DIR_IDX_W-1:0] dir_rd_idx, dir_wr_idx;
    logic [TB_IDX_W-1:0]  tb_rd_idx, tb_wr_idx;
    logic [TAG_W-1:0]     tb_rd_tag, tb_wr_tag;

    assign dir_rd_idx = fetch_pc[DIR_IDX_W+OFS_W-1:OFS_W];
    assign dir_wr_idx = upd_pc[DIR_IDX_W+OFS_W-1:OFS_W];
    assign tb_rd_idx  = fetch_pc[TAG_LSB-1:OFS_W];
    assign tb_wr_idx  = upd_pc[TAG_LSB-1:OFS_W];
    assign tb_rd_tag  = fetch_pc[PC_W-1:TAG_LSB];
    assign tb_wr_tag  = upd_pc[PC_W-1:TAG_LSB];

    nfa_dir_table #(
        .IDX_W(DIR_IDX_W)
    ) i_dir (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (dir_rd_idx),
        .rd_taken (dir_rd_taken),
        .wr_en    (upd_valid),
        .wr_idx   (dir_wr_idx),
        .wr_taken (upd_taken)
    );

    nfa_target_buffer #(
        .IDX_W (TB_IDX_W),
        .TAG_W (TAG_W),
        .ADDR_W(PC_W)
    ) i_tb (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (tb_rd_idx),
        .rd_tag    (tb_rd_tag),
        .rd_hit    (tb_hit),
        .rd_target (tb_target),
        .wr_en     (upd_valid),
        .wr_taken  (upd_taken),
        .wr_idx    (tb_wr_idx),
        .wr_tag    (tb_wr_tag),
        .wr_target (upd_target)
    );

    nfa_next_select #(
        .ADDR_W(PC_W)
    ) i_sel (
        .tb_hit     (tb_hit),
        .dir_taken  (dir_rd_taken),
        .fetch_pc   (fetch_pc),
        .tb_target  (tb_target),
        .pred_taken (pred_taken),
        .next_pc    (next_pc)
    );

    AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !pred_taken); // R1
    AST_FALL_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken |-> next_pc == fetch_pc + PC_W'(GROUP_BYTES)); // R2
    AST_TAKEN_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken |-> tb_hit && dir_rd_taken); // R4
    AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && upd_taken) |=>
            (fetch_pc != $past(upd_pc)) || (pred_taken && next_pc == $past(upd_target))); // R9
endmodule

// File: tb/test_nfa_predictor.sv
`timescale 1ns/1ps
module test_nfa_predictor;
    localparam int PC_W = 32;
    localparam int DW   = 2;
    localparam int BW   = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] fetch_pc = '0;
    logic            pred_taken;
    logic [PC_W-1:0] next_pc;
    logic            upd_valid = 1'b0;
    logic [PC_W-1:0] upd_pc = '0;
    logic            upd_taken = 1'b0;
    logic [PC_W-1:0] upd_target = '0;

    always #4 clk = ~clk;

    nfa_predictor #(.PC_W(PC_W), .DIR_IDX_W(DW), .TB_IDX_W(BW)) i_nfa_predictor (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_taken(pred_taken),
        .next_pc(next_pc), .upd_valid(upd_valid), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target)
    );

    // Behavioural reference state
    bit              m_dir   [int];
    bit              m_valid [int];
    logic [PC_W-1:0] m_tag   [int];
    logic [PC_W-1:0] m_tgt   [int];
    bit              any_taken;
    int              checks = 0;
    int              errors = 0;
    bit              done = 0;

    function automatic int dix(logic [PC_W-1:0] pc);
        return int'((pc >> 2) & ((1 << DW) - 1));
    endfunction
    function automatic int bix(logic [PC_W-1:0] pc);
        return int'((pc >> 2) & ((1 << BW) - 1));
    endfunction
    function automatic logic [PC_W-1:0] tg(logic [PC_W-1:0] pc);
        return pc >> (2 + BW);
    endfunction

    task automatic model_clear();
        m_dir.delete(); m_valid.delete(); m_tag.delete(); m_tgt.delete();
        for (int i = 0; i < (1 << DW); i++) m_dir[i] = 0;
        for (int i = 0; i < (1 << BW); i++) m_valid[i] = 0;
        any_taken = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; upd_valid = 1'b0;
        repeat (2) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One cycle: drive lookup and update, compare, then advance the model.
    task automatic step(input logic [PC_W-1:0] pc, input bit uv, input logic [PC_W-1:0] upc,
                        input bit ut, input logic [PC_W-1:0] utgt, input string req);
        bit              hit;
        bit              exp_t;
        logic [PC_W-1:0] exp_n;
        string           lbl;
        @(negedge clk);
        fetch_pc = pc; upd_valid = uv; upd_pc = upc; upd_taken = ut; upd_target = utgt;
        #1;
        hit   = m_valid[bix(pc)] && (m_tag[bix(pc)] == tg(pc));
        exp_t = hit && m_dir[dix(pc)];
        exp_n = exp_t ? m_tgt[bix(pc)] : pc + 32'd16;
        if (req != "") lbl = req;
        else if (!any_taken) lbl = "R1";
        else if (exp_t) lbl = "R4";
        else if (hit) lbl = "R5";
        else lbl = "R2";
        checks++;
        if (pred_taken !== exp_t || next_pc !== exp_n) begin
            errors++;
            $display("FAIL %s pc=%h pred_taken=%0b exp %0b next_pc=%h exp %h",
                     lbl, pc, pred_taken, exp_t, next_pc, exp_n);
        end
        @(posedge clk);
        if (uv) begin
            if (m_dir[dix(upc)] != ut) m_dir[dix(upc)] = ut;
            if (ut) begin
                m_valid[bix(upc)] = 1; m_tag[bix(upc)] = tg(upc); m_tgt[bix(upc)] = utgt;
                any_taken = 1;
            end
        end
    endtask

    task automatic look(input logic [PC_W-1:0] pc, input string req);
        step(pc, 0, '0, 0, '0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        // R1: cleared state predicts fall-through everywhere
        look(32'h0000_0100, "R1");
        look(32'h0000_0104, "R1");
        look(32'h1234_5678, "R1");
        // R9: lookup in the update cycle sees the old (empty) entry
        step(32'h0000_0100, 1, 32'h0000_0100, 1, 32'h0000_2000, "R9");
        // R7 / R4: installed target used from the next cycle
        look(32'h0000_0100, "R7");
        look(32'h0000_0100, "R4");
        // R3: same target index (0), different tag, flag 1 -> no hit
        look(32'h0000_0120, "R3");
        // R2: wrap-around of the sequential address
        look(32'hFFFF_FFF8, "R2");
        // R6: not-taken outcome clears the flag; R5: hit with flag 0
        step(32'h0000_0140, 1, 32'h0000_0100, 0, 32'h0000_3000, "R6");
        look(32'h0000_0100, "R5");
        // R8: restore flag 0 through an alias in another target entry
        step(32'h0000_0140, 1, 32'h0000_0110, 1, 32'h0000_4000, "R8");
        look(32'h0000_0100, "R8");
        look(32'h0000_0110, "R7");
        // R6: taken update on a flag already 1 keeps predicting taken
        step(32'h0000_0100, 1, 32'h0000_0110, 1, 32'h0000_4000, "R6");
        look(32'h0000_0100, "R6");
        // R7: overwrite entry 0 with a new tag; old address now misses
        step(32'h0000_0100, 1, 32'h0000_0120, 1, 32'h0000_5000, "R9");
        look(32'h0000_0120, "R7");
        look(32'h0000_0100, "R3");
        // Random traffic over two regions so tags collide
        for (int n = 0; n < 3000; n++) begin
            logic [PC_W-1:0] base_a, base_b, pa, pb, tt;
            base_a = ($urandom_range(0, 1) == 0) ? 32'h0000_1000 : 32'h0000_5000;
            base_b = ($urandom_range(0, 1) == 0) ? 32'h0000_1000 : 32'h0000_5000;
            pa = base_a + (32'($urandom_range(0, 31)) << 2);
            pb = base_b + (32'($urandom_range(0, 31)) << 2);
            tt = 32'($urandom) & 32'hFFFF_FFFC;
            step(pa, $urandom_range(0, 2) != 0, pb, $urandom_range(0, 1) == 1, tt, "");
        end
        // R1: a second reset clears everything learned
        do_reset();
        look(32'h0000_0100, "R1");
        look(32'h0000_0120, "R1");
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule